// File: doc/BRIEF.md
# Anti-tearing write sequencer

This block sits between a host write path and a byte-wide nonvolatile memory. It turns each host write request into a series of single-byte memory operations. Its purpose is that a write cut short by a power loss can always be finished later. In protected mode, the payload is first stored in a reserved record area of the memory, together with its destination and length. A marker byte then makes the record valid. After that the payload is copied to its destination, and the marker is cleared last. In direct mode, the payload goes straight to the destination.

After a power-up the block is told to check the record. If the marker is still valid, the block reads back the stored destination, length and payload, finishes the copy and clears the marker. While the block is busy, host requests are ignored; the busy output is meant to make the host interface refuse acknowledgement so the host has to poll. All persistent state, including the marker, lives in the memory and not in the block.

The record area starts at `BUF_BASE`. It holds the marker at offset 0, the destination address at offset 1, the length at offset 2 and the payload from offset 3 upward. The write-cycle time belongs to the memory, which reports completion through its handshake.

Top module: `tear_safe_writer`

## Requirements
- R1: While `rst_n` is low, `busy` and `mem_req` are low.
- R2: With `at_en` low, a request of n bytes produces exactly n memory writes. Byte k of `wr_data` (bits 8k+7..8k) goes to `wr_addr`+k, in ascending k, and nothing is written to the record area.
- R3: With `at_en` high, a request of n bytes produces 2n+4 writes in this order. First the payload goes to `BUF_BASE`+3+k. Then the destination address goes to `BUF_BASE`+1 and n to `BUF_BASE`+2. Next 0xA5 is written to `BUF_BASE`. Then the payload goes to `wr_addr`+k. Last, 0x00 is written to `BUF_BASE`.
- R4: A request length above `MAX_BYTES` (8) is treated as 8 bytes. A length of 0 starts no memory operation and leaves `busy` low.
- R5: Once `mem_req` is raised, it stays high with stable `mem_we`, `mem_addr` and `mem_wdata` until the cycle in which `mem_done` is seen.
- R6: A write request that arrives while `busy` is high has no effect on memory.
- R7: A `pwr_up` pulse in idle first reads `BUF_BASE`. If that byte is not 0xA5, the block returns to idle after that single read and makes no write.
- R8: If the marker reads 0xA5, the block reads `BUF_BASE`+1, `BUF_BASE`+2 and then each payload byte. It writes the payload to the stored destination in ascending order and then writes 0x00 to `BUF_BASE`. `busy` is high from the cycle after `pwr_up` until this sequence ends.
- R9: A reset during the destination phase of a protected write leaves the marker set. The next `pwr_up` completes every destination byte with the buffered payload.
- R10: A reset before the marker is written leaves no replay: the next `pwr_up` makes one read and no write, and the destination keeps its old contents.
- R11: On recovery, a stored length above 8 is replayed as 8 bytes. A stored length of 0 leads straight to the marker-clearing write.
- R12: When `pwr_up` and `wr_req` arrive in the same idle cycle, the power-up check is done and the write request is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset, models loss of power |
| pwr_up | input | 1 | One-cycle pulse that starts the record check |
| at_en | input | 1 | Selects protected mode for the request presented with it |
| wr_req | input | 1 | One-cycle write request strobe |
| wr_addr | input | ADDR_W (8) | Destination address of the first byte |
| wr_len | input | LEN_W (4) | Requested byte count |
| wr_data | input | 8*MAX_BYTES (64) | Payload, byte k in bits 8k+7..8k |
| busy | output | 1 | High while a sequence is running; host must be refused |
| mem_req | output | 1 | Memory operation request |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | ADDR_W (8) | Memory byte address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid in the cycle `mem_done` is high |
| mem_done | input | 1 | One-cycle completion of the current operation |

## Verification
The hardest situation to reach is a write torn in the middle of its destination phase. The marker must then be set and the destination must be only partly updated. The bench counts completed writes in its memory model and pulls reset low exactly when two destination bytes have landed. It confirms that the torn state is really present before it pulses `pwr_up`. A second tear is placed inside the payload-to-record phase, before the marker write. Records with oversized and zero lengths are written into the model memory directly, so the recovery paths run without any tear at all.

// File: rtl/atw_pkg.sv
package atw_pkg;
   // Sequencer states, grouped by phase: record fill, destination copy, replay.
   typedef enum logic [3:0] {
      ST_IDLE,
      ST_BDATA,
      ST_BADDR,
      ST_BLEN,
      ST_BMARK,
      ST_DDATA,
      ST_CLR,
      ST_RFLAG,
      ST_RADDR,
      ST_RLEN,
      ST_RDATA
   } atw_state_e;

   // Byte offsets inside the record area.
   localparam int unsigned OFS_MARK = 0;
   localparam int unsigned OFS_ADDR = 1;
   localparam int unsigned OFS_LEN  = 2;
   localparam int unsigned OFS_DATA = 3;
endpackage

// File: rtl/atw_stage.sv
module atw_stage #(
   parameter int unsigned MAX_BYTES = 8,
   parameter int unsigned IDX_W     = 3
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   ld_all,
   input  logic [8*MAX_BYTES-1:0] all_data,
   input  logic                   ld_one,
   input  logic [IDX_W-1:0]       idx,
   input  logic [7:0]             one_byte,
   output logic [7:0]             sel_byte
);
   logic [8*MAX_BYTES-1:0] flat;

   for (genvar g = 0; g < MAX_BYTES; g++) begin : g_slot
      logic [7:0] slot_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            slot_q <= '0;
         else if (ld_all)
            slot_q <= all_data[8*g +: 8];
         else if (ld_one && idx == IDX_W'(g))
            slot_q <= one_byte;
      end
      assign flat[8*g +: 8] = slot_q;
   end

   assign sel_byte = flat[{idx, 3'b000} +: 8];

   // R8: a host load and a replay load never compete for the slots
   a_r8_load_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(ld_all && ld_one));
endmodule

// File: rtl/atw_ctrl.sv
module atw_ctrl
   import atw_pkg::*;
#(
   parameter int unsigned     ADDR_W     = 8,
   parameter int unsigned     MAX_BYTES  = 8,
   parameter int unsigned     LEN_W      = 4,
   parameter int unsigned     IDX_W      = 3,
   parameter logic [ADDR_W-1:0] BUF_BASE = ADDR_W'('hF0),
   parameter logic [7:0]      VALID_MARK = 8'hA5,
   parameter logic [7:0]      CLEAR_MARK = 8'h00
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pwr_up,
   input  logic              at_en,
   input  logic              wr_req,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [LEN_W-1:0]  wr_len,
   output logic              busy,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [7:0]        mem_wdata,
   input  logic [7:0]        mem_rdata,
   input  logic              mem_done,
   output logic              ld_all,
   output logic              ld_one,
   output logic [IDX_W-1:0]  idx,
   input  logic [7:0]        stage_byte
);
   localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(MAX_BYTES);

   atw_state_e        st_q;
   logic [LEN_W-1:0]  cnt_q, len_q;
   logic [ADDR_W-1:0] dst_q;
   logic              at_q;
   logic              last;
   logic              accept;
   logic [LEN_W-1:0]  rd_len;

   assign last   = (cnt_q == len_q - LEN_W'(1));
   assign accept = (st_q == ST_IDLE) && !pwr_up && wr_req && (wr_len != '0);
   assign rd_len = (mem_rdata > 8'(MAX_BYTES)) ? LEN_MAX : LEN_W'(mem_rdata);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_IDLE;
         cnt_q <= '0;
         len_q <= '0;
         dst_q <= '0;
         at_q  <= 1'b0;
      end else if (st_q == ST_IDLE) begin
         cnt_q <= '0;
         if (pwr_up) begin
            st_q <= ST_RFLAG;
            at_q <= 1'b1;
         end else if (accept) begin
            len_q <= (wr_len > LEN_MAX) ? LEN_MAX : wr_len;
            dst_q <= wr_addr;
            at_q  <= at_en;
            st_q  <= at_en ? ST_BDATA : ST_DDATA;
         end
      end else if (mem_done) begin
         case (st_q)
            ST_BDATA: begin
               if (last) begin
                  st_q  <= ST_BADDR;
                  cnt_q <= '0;
               end else
                  cnt_q <= cnt_q + LEN_W'(1);
            end
            ST_BADDR: st_q <= ST_BLEN;
            ST_BLEN:  st_q <= ST_BMARK;
            ST_BMARK: begin
               st_q  <= ST_DDATA;
               cnt_q <= '0;
            end
            ST_DDATA: begin
               if (last)
                  st_q <= at_q ? ST_CLR : ST_IDLE;
               else
                  cnt_q <= cnt_q + LEN_W'(1);
            end
            ST_CLR:   st_q <= ST_IDLE;
            ST_RFLAG: st_q <= (mem_rdata == VALID_MARK) ? ST_RADDR : ST_IDLE;
            ST_RADDR: begin
               dst_q <= ADDR_W'(mem_rdata);
               st_q  <= ST_RLEN;
            end
            ST_RLEN: begin
               len_q <= rd_len;
               cnt_q <= '0;
               st_q  <= (rd_len == '0) ? ST_CLR : ST_RDATA;
            end
            ST_RDATA: begin
               if (last) begin
                  st_q  <= ST_DDATA;
                  cnt_q <= '0;
               end else
                  cnt_q <= cnt_q + LEN_W'(1);
            end
            default:  st_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      mem_addr  = BUF_BASE;
      mem_wdata = CLEAR_MARK;
      mem_we    = 1'b1;
      case (st_q)
         ST_BDATA: begin
            mem_addr  = BUF_BASE + ADDR_W'(OFS_DATA) + ADDR_W'(cnt_q);
            mem_wdata = stage_byte;
         end
         ST_BADDR: begin
            mem_addr  = BUF_BASE + ADDR_W'(OFS_ADDR);
            mem_wdata = 8'(dst_q);
         end
         ST_BLEN: begin
            mem_addr  = BUF_BASE + ADDR_W'(OFS_LEN);
            mem_wdata = 8'(len_q);
         end
         ST_BMARK: mem_wdata = VALID_MARK;
         ST_DDATA: begin
            mem_addr  = dst_q + ADDR_W'(cnt_q);
            mem_wdata = stage_byte;
         end
         ST_RFLAG: mem_we = 1'b0;
         ST_RADDR: begin
            mem_addr = BUF_BASE + ADDR_W'(OFS_ADDR);
            mem_we   = 1'b0;
         end
         ST_RLEN: begin
            mem_addr = BUF_BASE + ADDR_W'(OFS_LEN);
            mem_we   = 1'b0;
         end
         ST_RDATA: begin
            mem_addr = BUF_BASE + ADDR_W'(OFS_DATA) + ADDR_W'(cnt_q);
            mem_we   = 1'b0;
         end
         default: ;
      endcase
   end

   assign busy    = (st_q != ST_IDLE);
   assign mem_req = busy;
   assign ld_all  = accept;
   assign ld_one  = (st_q == ST_RDATA) && mem_done;
   assign idx     = cnt_q[IDX_W-1:0];

   // R5: an open request keeps its direction, address and data
   a_r5_req_held: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_done) |=> (mem_req && $stable(mem_we) &&
                                  $stable(mem_addr) && $stable(mem_wdata)));

   // R4: byte counters stay inside the clipped length
   a_r4_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_BDATA || st_q == ST_DDATA || st_q == ST_RDATA)
         |-> (cnt_q < len_q && len_q <= LEN_MAX));

   // R3: the destination copy starts right after the marker write completes
   a_r3_dest_after_mark: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_BMARK && mem_done) |=> (mem_req && mem_we && mem_addr == dst_q));

   // R7: a power-up check opens with a read of the marker byte
   a_r7_flag_read_first: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(busy) && $past(pwr_up)) |-> (mem_addr == BUF_BASE && !mem_we));
endmodule

// File: rtl/tear_safe_writer.sv
module tear_safe_writer #(
   parameter int unsigned       ADDR_W     = 8,
   parameter int unsigned       MAX_BYTES  = 8,
   parameter int unsigned       LEN_W      = 4,
   parameter logic [ADDR_W-1:0] BUF_BASE   = ADDR_W'('hF0),
   parameter logic [7:0]        VALID_MARK = 8'hA5,
   parameter logic [7:0]        CLEAR_MARK = 8'h00
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   pwr_up,
   input  logic                   at_en,
   input  logic                   wr_req,
   input  logic [ADDR_W-1:0]      wr_addr,
   input  logic [LEN_W-1:0]       wr_len,
   input  logic [8*MAX_BYTES-1:0] wr_data,
   output logic                   busy,
   output logic                   mem_req,
   output logic                   mem_we,
   output logic [ADDR_W-1:0]      mem_addr,
   output logic [7:0]             mem_wdata,
   input  logic [7:0]             mem_rdata,
   input  logic                   mem_done
);
   localparam int unsigned IDX_W   = $clog2(MAX_BYTES);
   localparam int unsigned REC_END = int'(BUF_BASE) + atw_pkg::OFS_DATA + MAX_BYTES;

   if (MAX_BYTES < 2) begin : g_bad_bytes
      $error("MAX_BYTES must be at least 2");
   end
   if (ADDR_W > 8 || ADDR_W < 4) begin : g_bad_addr
      $error("ADDR_W must lie in 4..8 so the address fits one record byte");
   end
   if (MAX_BYTES >= (1 << LEN_W)) begin : g_bad_len
      $error("LEN_W too narrow for MAX_BYTES");
   end
   if (REC_END > (1 << ADDR_W)) begin : g_bad_base
      $error("record area runs past the top of memory");
   end
   if (VALID_MARK == CLEAR_MARK) begin : g_bad_mark
      $error("valid and clear markers must differ");
   end

   logic             ld_all, ld_one;
   logic [IDX_W-1:0] idx;
   logic [7:0]       stage_byte;

   atw_stage #(
      .MAX_BYTES (MAX_BYTES),
      .IDX_W     (IDX_W)
   ) u_stage (
      .clk      (clk),
      .rst_n    (rst_n),
      .ld_all   (ld_all),
      .all_data (wr_data),
      .ld_one   (ld_one),
      .idx      (idx),
      .one_byte (mem_rdata),
      .sel_byte (stage_byte)
   );

   atw_ctrl #(
      .ADDR_W     (ADDR_W),
      .MAX_BYTES  (MAX_BYTES),
      .LEN_W      (LEN_W),
      .IDX_W      (IDX_W),
      .BUF_BASE   (BUF_BASE),
      .VALID_MARK (VALID_MARK),
      .CLEAR_MARK (CLEAR_MARK)
   ) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .pwr_up     (pwr_up),
      .at_en      (at_en),
      .wr_req     (wr_req),
      .wr_addr    (wr_addr),
      .wr_len     (wr_len),
      .busy       (busy),
      .mem_req    (mem_req),
      .mem_we     (mem_we),
      .mem_addr   (mem_addr),
      .mem_wdata  (mem_wdata),
      .mem_rdata  (mem_rdata),
      .mem_done   (mem_done),
      .ld_all     (ld_all),
      .ld_one     (ld_one),
      .idx        (idx),
      .stage_byte (stage_byte)
   );

   // R1: reset holds the block quiet on the memory side
   a_r1_quiet_in_reset: assert property (@(posedge clk) !rst_n |-> (!busy && !mem_req));
endmodule

// File: tb/tear_safe_writer_bench.sv
`timescale 1ns/1ps
module tear_safe_writer_bench;
   localparam int BUF = 'hF0;
   localparam int LAT = 3;
   localparam int NV  = 6;
   // {at_en, addr[7:0], len[3:0], data[63:0]}
   localparam logic [76:0] VEC [NV] = '{
      {1'b0, 8'h10, 4'd3,  64'h0000_0000_0033_2211},
      {1'b1, 8'h30, 4'd8,  64'h8877_6655_4433_2211},
      {1'b1, 8'h50, 4'd12, 64'hF1E2_D3C4_B5A6_9788},
      {1'b0, 8'h70, 4'd15, 64'h0102_0304_0506_0708},
      {1'b1, 8'h90, 4'd1,  64'h0000_0000_0000_005A},
      {1'b0, 8'h08, 4'd8,  64'hDEAD_BEEF_CAFE_F00D}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pwr_up = 1'b0, at_en = 1'b0, wr_req = 1'b0;
   logic [7:0]  wr_addr = '0;
   logic [3:0]  wr_len = '0;
   logic [63:0] wr_data = '0;
   logic        busy, mem_req, mem_we;
   logic [7:0]  mem_addr, mem_wdata;
   logic [7:0]  mem_rdata = '0;
   logic        mem_done = 1'b0;

   int checks = 0, errors = 0;

   always #2.5 clk = ~clk;

   tear_safe_writer u_tear_safe_writer (
      .clk(clk), .rst_n(rst_n), .pwr_up(pwr_up), .at_en(at_en), .wr_req(wr_req),
      .wr_addr(wr_addr), .wr_len(wr_len), .wr_data(wr_data), .busy(busy),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .mem_done(mem_done)
   );

   // memory model: contents persist across reset; reset aborts an open operation
   logic [7:0] mem [256];
   logic [7:0] lg_a [256];
   logic [7:0] lg_d [256];
   int         wcnt = 0, rcnt = 0, lat_q = 0, hs_err = 0;
   logic       pre_en = 1'b0;
   logic [7:0] pre_a = '0, pre_d = '0;
   logic       pend_q = 1'b0, p_we = 1'b0;
   logic [7:0] p_a = '0, p_d = '0;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lat_q    <= 0;
         mem_done <= 1'b0;
      end else begin
         if (pre_en) mem[pre_a] <= pre_d;
         if (mem_req && !mem_done) begin
            if (lat_q == LAT-1) begin
               lat_q    <= 0;
               mem_done <= 1'b1;
               if (mem_we) begin
                  mem[mem_addr]   <= mem_wdata;
                  lg_a[wcnt % 256] <= mem_addr;
                  lg_d[wcnt % 256] <= mem_wdata;
                  wcnt            <= wcnt + 1;
               end else begin
                  mem_rdata <= mem[mem_addr];
                  rcnt      <= rcnt + 1;
               end
            end else
               lat_q <= lat_q + 1;
         end else
            mem_done <= 1'b0;
      end
   end

   // R5 monitor: an open request must not change before completion
   always @(posedge clk) begin
      if (rst_n && pend_q &&
          (!mem_req || mem_we != p_we || mem_addr != p_a || mem_wdata != p_d))
         hs_err <= hs_err + 1;
      pend_q <= rst_n && mem_req && !mem_done;
      p_we   <= mem_we;
      p_a    <= mem_addr;
      p_d    <= mem_wdata;
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic poke(input int a, input int d);
      @(negedge clk);
      pre_en = 1'b1; pre_a = 8'(a); pre_d = 8'(d);
      @(negedge clk);
      pre_en = 1'b0;
   endtask

   task automatic host_write(input bit at, input int a, input int n, input logic [63:0] d);
      @(negedge clk);
      wr_req = 1'b1; at_en = at; wr_addr = 8'(a); wr_len = 4'(n); wr_data = d;
      @(negedge clk);
      wr_req = 1'b0;
   endtask

   task automatic pulse_pwr();
      @(negedge clk);
      pwr_up = 1'b1;
      @(negedge clk);
      pwr_up = 1'b0;
   endtask

   task automatic wait_idle();
      for (int n = 0; n < 5000 && busy; n++) @(negedge clk);
   endtask

   task automatic wait_wcnt(input int target);
      for (int n = 0; n < 5000 && wcnt != target; n++) @(negedge clk);
   endtask

   function automatic void exp_entry(input bit at, input int a, input int n,
                                     input logic [63:0] d, input int k,
                                     output int ea, output int ed);
      if (!at) begin ea = a + k; ed = int'(d[8*k +: 8]); end
      else if (k < n)     begin ea = BUF + 3 + k; ed = int'(d[8*k +: 8]); end
      else if (k == n)    begin ea = BUF + 1; ed = a; end
      else if (k == n+1)  begin ea = BUF + 2; ed = n; end
      else if (k == n+2)  begin ea = BUF;     ed = 'hA5; end
      else if (k < 2*n+3) begin ea = a + k - n - 3; ed = int'(d[8*(k-n-3) +: 8]); end
      else                begin ea = BUF;     ed = 0; end
      ea = ea & 'hFF;
   endfunction

   initial begin : watchdog
      #(5.0 * 150000);
      checks++; errors++;
      $display("FAIL watchdog run did not finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      int w0, r0, ea, ed, bad_k, n;
      bit at, ok;
      // R1: reset state
      repeat (3) @(negedge clk);
      chk(!busy && !mem_req, "R1", "outputs in reset", {busy, mem_req}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy, "R1", "busy after reset", busy, 0);

      // table of write requests, R2 R3 R4
      for (int v = 0; v < NV; v++) begin
         at = VEC[v][76];
         n  = (int'(VEC[v][67:64]) > 8) ? 8 : int'(VEC[v][67:64]);
         w0 = wcnt;
         host_write(at, int'(VEC[v][75:68]), int'(VEC[v][67:64]), VEC[v][63:0]);
         wait_idle();
         ok = (wcnt - w0) == (at ? 2*n+4 : n);
         bad_k = -1;
         for (int k = 0; k < wcnt - w0; k++) begin
            exp_entry(at, int'(VEC[v][75:68]), n, VEC[v][63:0], k, ea, ed);
            if (bad_k < 0 && (int'(lg_a[(w0+k)%256]) != ea || int'(lg_d[(w0+k)%256]) != ed))
               bad_k = k;
         end
         if (VEC[v][67:64] > 8)
            chk(ok && bad_k < 0, "R4", "clipped write sequence (count, first bad step)",
                (wcnt - w0) * 256 + bad_k, (at ? 2*n+4 : n) * 256 - 1);
         else if (at)
            chk(ok && bad_k < 0, "R3", "protected write sequence (count, first bad step)",
                (wcnt - w0) * 256 + bad_k, (2*n+4) * 256 - 1);
         else
            chk(ok && bad_k < 0, "R2", "direct write sequence (count, first bad step)",
                (wcnt - w0) * 256 + bad_k, n * 256 - 1);
      end

      // R4: zero length does nothing
      w0 = wcnt;
      host_write(1'b1, 'h44, 0, 64'h99);
      chk(!busy, "R4", "busy after zero-length request", busy, 0);
      repeat (10) @(negedge clk);
      chk(wcnt == w0, "R4", "writes after zero-length request", wcnt - w0, 0);

      // R7: marker clear, single read
      w0 = wcnt; r0 = rcnt;
      pulse_pwr();
      wait_idle();
      chk(rcnt - r0 == 1 && wcnt == w0, "R7", "reads*256+writes on clear marker",
          (rcnt - r0) * 256 + (wcnt - w0), 256);

      // R12: power-up wins over a same-cycle request
      poke('h68, 'h22);
      w0 = wcnt; r0 = rcnt;
      @(negedge clk);
      pwr_up = 1'b1; wr_req = 1'b1; at_en = 1'b0; wr_addr = 8'h68; wr_len = 4'd1; wr_data = 64'h55;
      @(negedge clk);
      pwr_up = 1'b0; wr_req = 1'b0;
      wait_idle();
      chk(wcnt == w0 && rcnt - r0 == 1 && mem[8'h68] == 8'h22, "R12",
          "byte at 68 after same-cycle pwr_up and request", int'(mem[8'h68]), 'h22);

      // R9: tear during destination phase
      for (int i = 0; i < 4; i++) poke('h20 + i, 'hEE);
      poke('h60, 'h11);
      w0 = wcnt;
      host_write(1'b1, 'h20, 4, 64'h0000_0000_D4C3_B2A1);
      wait_wcnt(w0 + 4 + 3 + 2);
      rst_n = 1'b0;
      @(negedge clk); @(negedge clk);
      chk(!busy && !mem_req, "R1", "outputs during mid-write reset", {busy, mem_req}, 0);
      rst_n = 1'b1;
      chk(mem[8'h21] == 8'hB2 && mem[8'h22] == 8'hEE && mem[8'hF0] == 8'hA5, "R9",
          "torn state byte 22", int'(mem[8'h22]), 'hEE);
      w0 = wcnt; r0 = rcnt;
      pulse_pwr();
      chk(busy, "R8", "busy during recovery", busy, 1);
      host_write(1'b0, 'h60, 1, 64'h77);
      wait_idle();
      chk(mem[8'h20] == 8'hA1 && mem[8'h21] == 8'hB2 && mem[8'h22] == 8'hC3 &&
          mem[8'h23] == 8'hD4, "R9", "restored bytes 22..23",
          int'({mem[8'h23], mem[8'h22]}), 'hD4C3);
      chk(wcnt - w0 == 5 && rcnt - r0 == 7 && mem[8'hF0] == 8'h00, "R8",
          "recovery writes*256+reads", (wcnt - w0) * 256 + (rcnt - r0), 5 * 256 + 7);
      chk(mem[8'h60] == 8'h11, "R6", "byte at 60 after request during busy",
          int'(mem[8'h60]), 'h11);

      // R10: tear before the marker
      for (int i = 0; i < 4; i++) poke('h28 + i, 'hEE);
      w0 = wcnt;
      host_write(1'b1, 'h28, 4, 64'h0000_0000_4433_2211);
      wait_wcnt(w0 + 2);
      rst_n = 1'b0;
      @(negedge clk); @(negedge clk);
      rst_n = 1'b1;
      w0 = wcnt; r0 = rcnt;
      pulse_pwr();
      wait_idle();
      chk(wcnt == w0 && rcnt - r0 == 1 && mem[8'h28] == 8'hEE, "R10",
          "writes after early tear", wcnt - w0, 0);

      // R11: stored length above maximum
      poke(BUF, 'hA5); poke(BUF + 1, 'h40); poke(BUF + 2, 'h0C);
      for (int i = 0; i < 8; i++) poke(BUF + 3 + i, 'hB0 + i);
      w0 = wcnt;
      pulse_pwr();
      wait_idle();
      ok = 1'b1;
      for (int i = 0; i < 8; i++) if (mem[8'h40 + i] != 8'(8'hB0 + i)) ok = 1'b0;
      chk(ok && wcnt - w0 == 9 && mem[8'hF0] == 8'h00, "R11",
          "replay writes for oversized stored length", wcnt - w0, 9);

      // R11: stored length zero
      poke(BUF, 'hA5); poke(BUF + 2, 'h00);
      w0 = wcnt; r0 = rcnt;
      pulse_pwr();
      wait_idle();
      chk(wcnt - w0 == 1 && rcnt - r0 == 3 && mem[8'hF0] == 8'h00, "R11",
          "writes*256+reads for zero stored length",
          (wcnt - w0) * 256 + (rcnt - r0), 256 + 3);

      // R5: handshake stability seen by the monitor over the whole run
      chk(hs_err == 0, "R5", "request changes before completion", hs_err, 0);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule